// File: doc/BRIEF.md
# Trigger-Aligned Line Address Generator

This block turns two trigger streams into write addresses for a sample buffer organised as lines of records. A record-start trigger opens one record of a configured number of samples. The block then raises a write strobe for one sample per cycle and presents the buffer address of each sample. Records fill a line back to back. After the configured number of records, the next record begins at the following line boundary with no gap.

A line-start trigger closes the current line early. The next record goes to the start of the next line. If the line had received fewer records than configured, the block writes a zero word into a separate per-line valid-flag area. Software fills that area with ones beforehand, so the block only ever writes zeros. Because a short line still occupies its full stride, every later line keeps its aligned position.

When the last line of the buffer has been used, the address wraps to line 0. A record-start trigger that arrives while a record is still being written is dropped and counted.

Top module: `line_addr_gen`

## Requirements
- R1: After reset, the write strobe and the flag strobe are low and the drop count is zero. The first accepted record starts at address 0.
- R2: A record-start trigger sampled on a clock edge while the strobe is low raises the write strobe in the next cycle. The strobe stays high for exactly `cfg_rec_len` cycles, and the address rises by one each cycle.
- R3: Within a line, record k (counting from 0) starts at line base + k × `cfg_rec_len`.
- R4: Once `cfg_recs_per_line` records of a line have finished, the next record starts at the next line base. Line i has base i × `cfg_rec_len` × `cfg_recs_per_line`.
- R5: A line-start trigger seen while the strobe is low, on a line holding between 1 and N−1 records, moves the next record to the next line base. It also pulses `flag_we` for one cycle in the cycle after that edge, with `flag_addr` equal to the short line's index and `flag_data` equal to 0.
- R6: A line-start trigger on a line holding zero records, or one that arrives during the N-th record, causes no flag write and no extra skip. Without line-start triggers, no flag write ever occurs.
- R7: With `cfg_flag_en` low, a short line still skips to the next line base, but `flag_we` stays low.
- R8: A record-start trigger sampled while the write strobe is high does not restart or lengthen the record. Each such trigger adds one to `drop_cnt`.
- R9: After line `cfg_lines`−1, the next line is line 0 at address 0.
- R10: A line-start trigger that arrives mid-record lets that record finish. On a short line, the flag pulse appears in the first cycle with the strobe low. A record-start and a line-start trigger on the same idle edge place the new record at the next line base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_trig | input | 1 | Record-start trigger, sampled each edge |
| b_trig | input | 1 | Line-start trigger, sampled each edge |
| cfg_rec_len | input | LEN_W | Samples per record (M) |
| cfg_recs_per_line | input | RPL_W | Records per line (N, at least 2) |
| cfg_lines | input | LINE_W | Lines per buffer |
| cfg_flag_en | input | 1 | Enables writes to the valid-flag area (low when that area is absent) |
| wr_en | output | 1 | Sample write strobe |
| wr_addr | output | ADDR_W | Sample write address |
| flag_we | output | 1 | Valid-flag write strobe |
| flag_addr | output | LINE_W | Valid-flag word index (line number) |
| flag_data | output | 32 | Valid-flag word, always zero |
| drop_cnt | output | DROP_W | Count of record-start triggers dropped while busy |

## Verification
The write strobe and the first sample address appear one cycle after the edge that accepts a record-start trigger. The last sample is due `cfg_rec_len` cycles later, and the strobe is low in the cycle after that. A flag pulse from an idle line-start trigger is due one cycle after its edge. When the trigger lands mid-record, the pulse comes in the same cycle the strobe first reads low. The bench drives inputs at falling edges and samples at the next falling edge, exactly that number of cycles on. It also checks the strobe and flag one cycle later to confirm they are single pulses of the right length.

// File: rtl/lag_pkg.sv
package lag_pkg;

    // How the current line is closed in a given cycle
    typedef enum logic [1:0] {
        ADV_NONE   = 2'd0,  // line stays open
        ADV_FULL   = 2'd1,  // N records done, natural step
        ADV_SHORT  = 2'd2,  // early line-start, line marked invalid
        ADV_ABSORB = 2'd3   // line-start on an empty line, no effect
    } adv_kind_e;

endpackage

// File: rtl/lag_rec_ctr.sv
module lag_rec_ctr #(
    parameter int LEN_W  = 16,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_trig,
    input  logic [LEN_W-1:0]  cfg_rec_len,
    output logic              busy,
    output logic [LEN_W-1:0]  smp_idx,
    output logic              rec_start,
    output logic              rec_done,
    output logic [DROP_W-1:0] drop_cnt
);

    typedef struct packed {
        logic              busy;
        logic [LEN_W-1:0]  smp;
        logic [DROP_W-1:0] drops;
    } rec_st_t;

    rec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rec_start = a_trig && !st_q.busy;
        rec_done  = st_q.busy && (st_q.smp == cfg_rec_len - LEN_W'(1));

        if (rec_start) begin
            st_d.busy = 1'b1;
            st_d.smp  = '0;
        end else if (st_q.busy) begin
            if (rec_done) begin
                st_d.busy = 1'b0;
                st_d.smp  = '0;
            end else begin
                st_d.smp = st_q.smp + LEN_W'(1);
            end
        end

        if (a_trig && st_q.busy) begin
            st_d.drops = st_q.drops + DROP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign smp_idx  = st_q.smp;
    assign drop_cnt = st_q.drops;

    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_trig && st_q.busy) |=> (st_q.drops == $past(st_q.drops) + DROP_W'(1))); // R8

    AST_SMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.smp < cfg_rec_len)); // R2

    AST_REC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.smp == cfg_rec_len - LEN_W'(1)) |=> !st_q.busy); // R2

endmodule

// File: rtl/lag_line_ctl.sv
module lag_line_ctl
    import lag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int RPL_W  = 16,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_trig,
    input  logic              busy,
    input  logic              rec_start,
    input  logic              rec_done,
    input  logic [LEN_W-1:0]  cfg_rec_len,
    input  logic [RPL_W-1:0]  cfg_recs_per_line,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic              cfg_flag_en,
    output logic [ADDR_W-1:0] rec_base,
    output logic              flag_we,
    output logic [LINE_W-1:0] flag_idx
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [ADDR_W-1:0] line_base;
        logic [ADDR_W-1:0] nxt_off;
        logic [ADDR_W-1:0] cur_off;
        logic [RPL_W-1:0]  rc;
        logic              pend;
        logic              flag_we;
        logic [LINE_W-1:0] flag_idx;
    } line_st_t;

    line_st_t  ln_d, ln_q;
    adv_kind_e kind;
    logic      pend;
    logic [ADDR_W-1:0] stride;

    always_comb begin
        stride = ADDR_W'(cfg_rec_len) * ADDR_W'(cfg_recs_per_line);
        ln_d         = ln_q;
        ln_d.flag_we = 1'b0;
        pend         = ln_q.pend || b_trig;
        kind         = ADV_NONE;

        // a full line closes first; a pending line-start waits for the record
        if (rec_done && ln_q.rc == cfg_recs_per_line) begin
            kind = ADV_FULL;
        end else if (pend && (!busy || rec_done)) begin
            kind = (ln_q.rc != '0) ? ADV_SHORT : ADV_ABSORB;
        end

        ln_d.pend = (kind == ADV_NONE) ? pend : 1'b0;

        if (kind == ADV_SHORT) begin
            ln_d.flag_we  = cfg_flag_en;
            ln_d.flag_idx = ln_q.line;
        end

        if (kind == ADV_FULL || kind == ADV_SHORT) begin
            if (ln_q.line == cfg_lines - LINE_W'(1)) begin
                ln_d.line      = '0;
                ln_d.line_base = '0;
            end else begin
                ln_d.line      = ln_q.line + LINE_W'(1);
                ln_d.line_base = ln_q.line_base + stride;
            end
            ln_d.nxt_off = '0;
            ln_d.rc      = '0;
        end

        // a record accepted this edge lands on the line as updated above
        if (rec_start) begin
            ln_d.cur_off = ln_d.nxt_off;
            ln_d.nxt_off = ln_d.nxt_off + ADDR_W'(cfg_rec_len);
            ln_d.rc      = ln_d.rc + RPL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign rec_base = ln_q.line_base + ln_q.cur_off;
    assign flag_we  = ln_q.flag_we;
    assign flag_idx = ln_q.flag_idx;

    AST_RC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.rc <= cfg_recs_per_line); // R4

    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.flag_we |-> cfg_flag_en); // R7

    AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.flag_we |=> !ln_q.flag_we); // R5

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.line < cfg_lines); // R9

    AST_FLAG_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.flag_we |-> (ln_q.rc <= RPL_W'(1))); // R6

endmodule

// File: rtl/line_addr_gen.sv
module line_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int RPL_W  = 16,
    parameter int LINE_W = 12,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_trig,
    input  logic              b_trig,
    input  logic [LEN_W-1:0]  cfg_rec_len,
    input  logic [RPL_W-1:0]  cfg_recs_per_line,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic              cfg_flag_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              flag_we,
    output logic [LINE_W-1:0] flag_addr,
    output logic [31:0]       flag_data,
    output logic [DROP_W-1:0] drop_cnt
);

    logic              busy;
    logic              rec_start;
    logic              rec_done;
    logic [LEN_W-1:0]  smp_idx;
    logic [ADDR_W-1:0] rec_base;

    lag_rec_ctr #(
        .LEN_W  (LEN_W),
        .DROP_W (DROP_W)
    ) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_trig      (a_trig),
        .cfg_rec_len (cfg_rec_len),
        .busy        (busy),
        .smp_idx     (smp_idx),
        .rec_start   (rec_start),
        .rec_done    (rec_done),
        .drop_cnt    (drop_cnt)
    );

    lag_line_ctl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .RPL_W  (RPL_W),
        .LINE_W (LINE_W)
    ) u_line (
        .clk               (clk),
        .rst_n             (rst_n),
        .b_trig            (b_trig),
        .busy              (busy),
        .rec_start         (rec_start),
        .rec_done          (rec_done),
        .cfg_rec_len       (cfg_rec_len),
        .cfg_recs_per_line (cfg_recs_per_line),
        .cfg_lines         (cfg_lines),
        .cfg_flag_en       (cfg_flag_en),
        .rec_base          (rec_base),
        .flag_we           (flag_we),
        .flag_idx          (flag_addr)
    );

    assign wr_en     = busy;
    assign wr_addr   = rec_base + ADDR_W'(smp_idx);
    assign flag_data = '0;

    AST_ADDR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1))); // R2

    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_trig && !wr_en) |=> wr_en); // R2

endmodule

// File: tb/line_addr_gen_test.sv
module line_addr_gen_test;

    localparam int ADDR_W = 24;
    localparam int LEN_W  = 16;
    localparam int RPL_W  = 16;
    localparam int LINE_W = 12;
    localparam int DROP_W = 16;
    localparam int M      = 32;
    localparam int N      = 3;
    localparam int L      = 3;

    // [15] line-start entry, [14] flag expected, [13:12] flag line, [9:0] record start address
    localparam logic [15:0] VEC [12] = '{
        16'h0000, 16'h0020, 16'h0040, 16'h0060,
        16'hD000, 16'h00C0, 16'h00E0, 16'h0100,
        16'h8000, 16'h0000, 16'hC000, 16'h0060
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              a_trig = 1'b0;
    logic              b_trig = 1'b0;
    logic [LEN_W-1:0]  cfg_rec_len = LEN_W'(M);
    logic [RPL_W-1:0]  cfg_recs_per_line = RPL_W'(N);
    logic [LINE_W-1:0] cfg_lines = LINE_W'(L);
    logic              cfg_flag_en = 1'b1;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              flag_we;
    logic [LINE_W-1:0] flag_addr;
    logic [31:0]       flag_data;
    logic [DROP_W-1:0] drop_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    line_addr_gen #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W), .RPL_W (RPL_W),
        .LINE_W (LINE_W), .DROP_W (DROP_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .a_trig (a_trig), .b_trig (b_trig),
        .cfg_rec_len (cfg_rec_len), .cfg_recs_per_line (cfg_recs_per_line),
        .cfg_lines (cfg_lines), .cfg_flag_en (cfg_flag_en),
        .wr_en (wr_en), .wr_addr (wr_addr), .flag_we (flag_we),
        .flag_addr (flag_addr), .flag_data (flag_data), .drop_cnt (drop_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string vec_req(input int idx);
        case (idx)
            0:       return "R2";
            3:       return "R4";
            4, 5:    return "R5";
            8:       return "R6";
            9:       return "R9";
            10, 11:  return "R5";
            default: return "R3";
        endcase
    endfunction

    // one record; optional dropped triggers and a mid-record line-start
    task automatic run_rec(input int exp_addr, input string req, input bit extra_a,
                           input bit b_mid, input bit exp_flag, input int fa);
        int bad = 0;
        @(negedge clk) a_trig = 1'b1;
        @(negedge clk) a_trig = 1'b0;
        chk(wr_en === 1'b1, req, "strobe after trigger", 32'(wr_en), 1);
        chk(wr_addr === ADDR_W'(exp_addr), req, "record start address", 32'(wr_addr), 32'(exp_addr));
        for (int i = 1; i < M; i++) begin
            @(negedge clk);
            if (wr_en !== 1'b1 || wr_addr !== ADDR_W'(exp_addr + i)) bad++;
            a_trig = extra_a && (i == 3 || i == 5);
            b_trig = b_mid && (i == 8);
        end
        chk(bad == 0, "R2", "samples off sequence", 32'(bad), 0);
        @(negedge clk);
        chk(wr_en === 1'b0, "R2", "strobe after M cycles", 32'(wr_en), 0);
        chk(flag_we === exp_flag, b_mid ? "R10" : req, "flag at record end", 32'(flag_we), 32'(exp_flag));
        if (exp_flag) begin
            chk(flag_addr === LINE_W'(fa), "R10", "flag line", 32'(flag_addr), 32'(fa));
        end
        @(negedge clk);
        chk(flag_we === 1'b0, "R5", "flag single pulse", 32'(flag_we), 0);
    endtask

    task automatic pulse_b(input string req, input bit exp_flag, input int fa);
        @(negedge clk) b_trig = 1'b1;
        @(negedge clk) b_trig = 1'b0;
        chk(flag_we === exp_flag, req, "flag after line-start", 32'(flag_we), 32'(exp_flag));
        if (exp_flag) begin
            chk(flag_addr === LINE_W'(fa), req, "flag line", 32'(flag_addr), 32'(fa));
            chk(flag_data === 32'd0, req, "flag word", flag_data, 0);
        end
        chk(wr_en === 1'b0, req, "no strobe from line-start", 32'(wr_en), 0);
        @(negedge clk);
        chk(flag_we === 1'b0, "R5", "flag single pulse", 32'(flag_we), 0);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(wr_en === 1'b0, "R1", "strobe in reset", 32'(wr_en), 0);
        chk(flag_we === 1'b0, "R1", "flag in reset", 32'(flag_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drop_cnt === '0, "R1", "drop count", 32'(drop_cnt), 0);
        chk(wr_en === 1'b0, "R1", "strobe idle", 32'(wr_en), 0);

        foreach (VEC[k]) begin
            if (VEC[k][15]) begin
                pulse_b(vec_req(k), VEC[k][14], int'(VEC[k][13:12]));
            end else begin
                run_rec(int'(VEC[k][9:0]), vec_req(k), 1'b0, 1'b0, 1'b0, 0);
            end
        end

        // R8: two triggers during a record are dropped and counted
        run_rec(128, "R8", 1'b1, 1'b0, 1'b0, 0);
        chk(drop_cnt === DROP_W'(2), "R8", "drop count", 32'(drop_cnt), 2);
        // R6: line-start during the N-th record: no flag, line 2 next
        run_rec(160, "R6", 1'b0, 1'b1, 1'b0, 0);
        run_rec(192, "R6", 1'b0, 1'b0, 1'b0, 0);
        // R10: line-start mid-record on a short line, flag at strobe fall, wrap
        run_rec(224, "R10", 1'b0, 1'b1, 1'b1, 2);
        run_rec(0, "R9", 1'b0, 1'b0, 1'b0, 0);
        // R7: flag writes disabled, skip still happens
        cfg_flag_en = 1'b0;
        pulse_b("R7", 1'b0, 0);
        run_rec(96, "R7", 1'b0, 1'b0, 1'b0, 0);
        cfg_flag_en = 1'b1;
        // R10: record-start and line-start on the same idle edge
        @(negedge clk) begin a_trig = 1'b1; b_trig = 1'b1; end
        @(negedge clk) begin a_trig = 1'b0; b_trig = 1'b0; end
        chk(wr_en === 1'b1, "R10", "strobe on joint trigger", 32'(wr_en), 1);
        chk(wr_addr === ADDR_W'(192), "R10", "joint trigger address", 32'(wr_addr), 192);
        chk(flag_we === 1'b1, "R10", "joint trigger flag", 32'(flag_we), 1);
        chk(flag_addr === LINE_W'(1), "R10", "joint trigger flag line", 32'(flag_addr), 1);
        repeat (M) @(negedge clk);
        chk(wr_en === 1'b0, "R2", "strobe after joint record", 32'(wr_en), 0);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule